// File: doc/BRIEF.md
# Serial Frequency Word Loader

This block is the programming front end of an integer-N synthesizer. A three-wire serial port (bit clock, bit data, target select) fills one of two shift buffers one bit per rising bit-clock edge, least significant bit first. The wide buffer holds a 20-bit frequency word that becomes the live divider setting only when a separate load strobe rises, so a new word can be shifted in while the loop keeps running on the old one. The narrow 8-bit buffer holds option bits that act as soon as they are shifted in.

A mode input lets the divider values bypass the serial path completely and come from static input pins instead; in that mode the prescaler bypass bit is always off. An active-low option enable decides whether the option bits act at all. Their low two bits choose which internal timing signal (main divider output, reference divider output or the modulus select) drives a single debug output. All serial inputs are sampled with the block's own system clock and their rising edges are found by comparing each sample against the previous one.

Top module: `fsyn_loader`

## Requirements
- R1: While reset is high at a clock edge, the active frequency word, the 20-bit shift buffer and the 8-bit option buffer become zero; after reset in serial mode all divider outputs and the debug output read 0.
- R2: With `ser_sel` low, each rising `ser_clk` edge shifts `ser_data` in LSB first; after 20 shifts and a load, bit positions [5:0] appear on `div_r`, [14:6] on `div_m`, [18:15] on `div_a` and bit 19 on `pre_bypass`.
- R3: Shifting never changes the divider outputs before the next rising edge of `load_strobe`.
- R4: A rising edge of `load_strobe` copies the 20-bit buffer into the active word; holding the strobe high copies nothing more.
- R5: With `ser_sel` high, shifts go to the 8-bit option buffer and leave the 20-bit buffer unchanged.
- R6: With `direct_mode` high, the divider outputs follow `dir_r`, `dir_m`, `dir_a` and `pre_bypass` is 0; the stored active word is kept and returns when `direct_mode` goes low.
- R7: With `enh_n` high, `dbg_out` is 0 whatever the option bits hold.
- R8: With `enh_n` low, option bits [1:0] choose `dbg_out`: 0 gives constant 0, 1 gives `main_tick`, 2 gives `ref_tick`, 3 gives `msel_in`; bits [7:2] have no effect.
- R9: Only a rising edge of `ser_clk` shifts; holding it high shifts once, and data changes while it stays high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock (sampled, rising edge shifts) |
| ser_data | input | 1 | Serial data bit |
| ser_sel | input | 1 | Shift target: 0 frequency buffer, 1 option buffer |
| load_strobe | input | 1 | Rising edge commits the frequency buffer |
| direct_mode | input | 1 | 1 takes divider values from the static pins |
| dir_r | input | 6 | Static reference divider value |
| dir_m | input | 9 | Static main divider value |
| dir_a | input | 4 | Static swallow count value |
| enh_n | input | 1 | Active-low enable of the option bits |
| main_tick | input | 1 | Main divider output for debug |
| ref_tick | input | 1 | Reference divider output for debug |
| msel_in | input | 1 | Prescaler modulus select for debug |
| div_r | output | 6 | Effective reference divider value |
| div_m | output | 9 | Effective main divider value |
| div_a | output | 4 | Effective swallow count value |
| pre_bypass | output | 1 | Effective prescaler bypass bit |
| dbg_out | output | 1 | Debug output |

## Verification
A corrupted active word shows on the divider outputs at once in serial mode, while a wrong bit in the 20-bit buffer stays hidden until the next load and then appears in the field its position decodes to, one clock after the strobe edge. A wrong option bit shows on the debug output in the same cycle whenever the option enable is low, so the bench sweeps every select code against every tick combination. Walking-one words and arithmetic patterns expose swapped or shifted field boundaries and an inverted shift direction.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;

    localparam int R_W    = 6;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int WORD_W = R_W + M_W + A_W + 1;
    localparam int OPT_W  = 8;
    localparam int SEL_W  = 2;

    // Packed MSB first, so the reference field sits at the low end.
    typedef struct packed {
        logic           bypass;
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
    } freq_word_t;

    typedef enum logic [SEL_W-1:0] {
        DBG_LOW  = 2'd0,
        DBG_MAIN = 2'd1,
        DBG_REF  = 2'd2,
        DBG_MSEL = 2'd3
    } dbg_sel_t;

    typedef struct packed {
        logic [OPT_W-SEL_W-1:0] spare;
        dbg_sel_t               dsel;
    } opt_word_t;

    function automatic freq_word_t pin_word(
        input logic [R_W-1:0] r,
        input logic [M_W-1:0] m,
        input logic [A_W-1:0] a
    );
        freq_word_t w;
        w.bypass = 1'b0;
        w.a      = a;
        w.m      = m;
        w.r      = r;
        return w;
    endfunction

endpackage

// File: rtl/fsyn_rise_det.sv
module fsyn_rise_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/fsyn_shift_lsb.sv
module fsyn_shift_lsb #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {din, q[W-1:1]};
        end
    end
endmodule

// File: rtl/fsyn_dbg_mux.sv
module fsyn_dbg_mux
    import fsyn_pkg::*;
(
    input  opt_word_t opt,
    input  logic      enh_n,
    input  logic      main_tick,
    input  logic      ref_tick,
    input  logic      msel_in,
    output logic      dbg_out
);
    logic unused_opt_spare;
    assign unused_opt_spare = ^opt.spare;

    always_comb begin
        dbg_out = 1'b0;
        if (!enh_n) begin
            unique case (opt.dsel)
                DBG_LOW:  dbg_out = 1'b0;
                DBG_MAIN: dbg_out = main_tick;
                DBG_REF:  dbg_out = ref_tick;
                DBG_MSEL: dbg_out = msel_in;
                default:  dbg_out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fsyn_loader.sv
module fsyn_loader
    import fsyn_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_sel,
    input  logic           load_strobe,
    input  logic           direct_mode,
    input  logic [R_W-1:0] dir_r,
    input  logic [M_W-1:0] dir_m,
    input  logic [A_W-1:0] dir_a,
    input  logic           enh_n,
    input  logic           main_tick,
    input  logic           ref_tick,
    input  logic           msel_in,
    output logic [R_W-1:0] div_r,
    output logic [M_W-1:0] div_m,
    output logic [A_W-1:0] div_a,
    output logic           pre_bypass,
    output logic           dbg_out
);
    localparam int N_STROBES = 2;
    localparam int IDX_SCLK  = 0;
    localparam int IDX_LOAD  = 1;

    logic [N_STROBES-1:0] rise;
    logic [WORD_W-1:0]    pri_q;
    logic [OPT_W-1:0]     opt_q;
    freq_word_t           act_q;
    freq_word_t           eff_w;

    fsyn_rise_det #(.N(N_STROBES)) u_rise (
        .clk    (clk),
        .sig_in ({load_strobe, ser_clk}),
        .rise   (rise)
    );

    fsyn_shift_lsb #(.W(WORD_W)) u_pri_sr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rise[IDX_SCLK] & ~ser_sel),
        .din      (ser_data),
        .q        (pri_q)
    );

    fsyn_shift_lsb #(.W(OPT_W)) u_opt_sr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rise[IDX_SCLK] & ser_sel),
        .din      (ser_data),
        .q        (opt_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (rise[IDX_LOAD]) begin
            act_q <= freq_word_t'(pri_q);
        end
    end

    assign eff_w      = direct_mode ? pin_word(dir_r, dir_m, dir_a) : act_q;
    assign div_r      = eff_w.r;
    assign div_m      = eff_w.m;
    assign div_a      = eff_w.a;
    assign pre_bypass = eff_w.bypass;

    fsyn_dbg_mux u_dbg (
        .opt       (opt_word_t'(opt_q)),
        .enh_n     (enh_n),
        .main_tick (main_tick),
        .ref_tick  (ref_tick),
        .msel_in   (msel_in),
        .dbg_out   (dbg_out)
    );
endmodule

// File: rtl/fsyn_loader_chk.sv
module fsyn_loader_chk
    import fsyn_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ser_clk,
    input logic              ser_sel,
    input logic              load_strobe,
    input logic              direct_mode,
    input logic              enh_n,
    input logic              pre_bypass,
    input logic              dbg_out,
    input logic [WORD_W-1:0] act_word,
    input logic [WORD_W-1:0] pri_word,
    input logic [OPT_W-1:0]  opt_word
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (act_word == '0 && pri_word == '0 && opt_word == '0));

    // R3
    a_r3_hold_active: assert property (@(posedge clk) disable iff (rst)
        !(load_strobe && !$past(load_strobe)) |=> $stable(act_word));

    // R4
    a_r4_commit_copy: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && !$past(load_strobe)) |=> (act_word == $past(pri_word)));

    // R5
    a_r5_opt_spares_primary: assert property (@(posedge clk) disable iff (rst)
        ser_sel |=> $stable(pri_word));

    // R6
    a_r6_direct_no_bypass: assert property (@(posedge clk) disable iff (rst)
        direct_mode |-> !pre_bypass);

    // R7
    a_r7_dbg_off: assert property (@(posedge clk) disable iff (rst)
        enh_n |-> !dbg_out);

    // R9
    a_r9_level_no_shift: assert property (@(posedge clk) disable iff (rst)
        !(ser_clk && !$past(ser_clk)) |=> ($stable(pri_word) && $stable(opt_word)));
endmodule

bind fsyn_loader fsyn_loader_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .ser_sel     (ser_sel),
    .load_strobe (load_strobe),
    .direct_mode (direct_mode),
    .enh_n       (enh_n),
    .pre_bypass  (pre_bypass),
    .dbg_out     (dbg_out),
    .act_word    (act_q),
    .pri_word    (pri_q),
    .opt_word    (opt_q)
);

// File: tb/fsyn_loader_tb.sv
module fsyn_loader_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_sel = 1'b0;
    logic       load_strobe = 1'b0, direct_mode = 1'b0;
    logic [5:0] dir_r = '0;
    logic [8:0] dir_m = '0;
    logic [3:0] dir_a = '0;
    logic       enh_n = 1'b0, main_tick = 1'b0, ref_tick = 1'b0, msel_in = 1'b0;
    logic [5:0] div_r;
    logic [8:0] div_m;
    logic [3:0] div_a;
    logic       pre_bypass, dbg_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fsyn_loader dut_i (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_sel(ser_sel), .load_strobe(load_strobe), .direct_mode(direct_mode),
        .dir_r(dir_r), .dir_m(dir_m), .dir_a(dir_a), .enh_n(enh_n),
        .main_tick(main_tick), .ref_tick(ref_tick), .msel_in(msel_in),
        .div_r(div_r), .div_m(div_m), .div_a(div_a),
        .pre_bypass(pre_bypass), .dbg_out(dbg_out)
    );

    function automatic logic [19:0] outs();
        return {pre_bypass, div_a, div_m, div_r};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // hold: cycles ser_clk stays high; data toggles while high
    task automatic shift_bits(input logic sel, input logic [31:0] val,
                              input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_sel  = sel;
            ser_data = val[i];
            ser_clk  = 1'b0;
            @(negedge clk);
            ser_clk = 1'b1;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                ser_data = ~ser_data;
            end
            ser_clk = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic commit();
        @(negedge clk);
        load_strobe = 1'b1;
        @(negedge clk);
        load_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] prev_w;
        logic [19:0] w;
        logic [19:0] w9;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: all cleared
        chk("R1 outputs after reset", 32'(outs()), 32'h0);
        chk("R1 dbg after reset", 32'(dbg_out), 32'h0);

        // R2, R3: walking ones and arithmetic patterns
        prev_w = '0;
        for (int i = 0; i < 28; i++) begin
            w = (i < 20) ? 20'(1 << i) : 20'((i * 32'h2F3B7 + 32'h15A5) & 32'hFFFFF);
            shift_bits(1'b0, 32'(w), 20, 1);
            chk("R3 no change before load", 32'(outs()), 32'(prev_w));
            commit();
            chk("R2 word after load", 32'(outs()), 32'(w));
            chk("R2 r field", 32'(div_r), 32'(w[5:0]));
            chk("R2 m field", 32'(div_m), 32'(w[14:6]));
            chk("R2 a field", 32'(div_a), 32'(w[18:15]));
            chk("R2 bypass bit", 32'(pre_bypass), 32'(w[19]));
            prev_w = w;
        end

        // R4: strobe held high copies once
        @(negedge clk);
        load_strobe = 1'b1;
        @(negedge clk);
        w = 20'hC3A5E;
        shift_bits(1'b0, 32'(w), 20, 1);
        chk("R4 held strobe no recopy", 32'(outs()), 32'(prev_w));
        load_strobe = 1'b0;
        commit();
        chk("R4 new edge copies", 32'(outs()), 32'(w));
        prev_w = w;

        // R5: option shifts leave the frequency buffer alone
        shift_bits(1'b1, 32'hA6, 8, 1);
        commit();
        chk("R5 primary untouched", 32'(outs()), 32'(prev_w));

        // R9: last bit with the clock held high while data toggles
        w9 = 20'h9B1D7;
        shift_bits(1'b0, 32'(w9), 19, 1);
        shift_bits(1'b0, 32'(w9 >> 19), 1, 6);
        commit();
        chk("R9 one shift per rise", 32'(outs()), 32'(w9));

        // R6: direct mode
        @(negedge clk);
        direct_mode = 1'b1;
        for (int k = 0; k < 16; k++) begin
            dir_r = 6'((k * 11) & 63);
            dir_m = 9'((k * 37 + 5) & 511);
            dir_a = 4'(k & 15);
            #1;
            chk("R6 direct pins", 32'(outs()), 32'({1'b0, dir_a, dir_m, dir_r}));
            @(negedge clk);
        end
        direct_mode = 1'b0;
        #1;
        chk("R6 stored word returns", 32'(outs()), 32'(w9));

        // R7, R8: every select with every enable / tick combination
        for (int s = 0; s < 4; s++) begin
            shift_bits(1'b1, 32'(((s * 13 + 7) << 2) | s), 8, 1);
            for (int c = 0; c < 16; c++) begin
                logic e;
                enh_n     = c[3];
                main_tick = c[0];
                ref_tick  = c[1];
                msel_in   = c[2];
                #1;
                case (s)
                    1: e = c[0];
                    2: e = c[1];
                    3: e = c[2];
                    default: e = 1'b0;
                endcase
                if (c[3]) chk("R7 dbg disabled", 32'(dbg_out), 32'h0);
                else      chk("R8 dbg select", 32'(dbg_out), 32'(e));
                @(negedge clk);
            end
        end
        enh_n = 1'b0;
        chk("R2 word kept after option shifts", 32'(outs()), 32'(w9));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule